// File: doc/BRIEF.md
# SPI Serial EEPROM Command Front-End

This block is the serial slave side of a small nonvolatile byte store of 128 locations. It watches the four host pins (serial clock, active-low select, serial data in, active-low hold), decodes a one-byte command, takes an address byte where the command needs one, and then either streams memory bytes or the status byte out on the serial data output, or hands each received data byte to a separate write-cycle engine. The pins are oversampled by the core clock `clk`. Every level on `sckIn`, `csN`, `siIn` and `holdN` must stay stable for at least four core clocks. The storage array sits behind a synchronous read port: `memRdData` is valid in the cycle after `memRdEn`.

The block keeps the write-enable latch itself. The write-cycle engine reports its busy flag on `busyIn`, and two block-protect bits arrive on `bpIn`. The page buffer, the self-timed programming and the enforcement of write protection are all outside this block. The block only presents bytes with their page-wrapped address and signals when a write sequence has closed validly.

The serial output is modelled as a data bit, `soOut`, plus an output enable, `soOe`. A pad cell outside the block turns these into a tri-state driver.

Top module: `spi_eeprom_front`

## Requirements
- R1: SI is sampled on rising SCK edges seen while select is low and hold is high. The first sample is the first rising edge after select falls, and every byte moves most-significant bit first.
- R2: Command 03h followed by an address byte starts a read. Only address bits 6..0 are used and bit 7 is ignored. The byte at that location appears on SO, MSB first, with each bit driven after a falling SCK edge, starting at the falling edge that follows the last address bit.
- R3: While clocks continue during a read, each further byte comes from the next address, and address 7Fh is followed by 00h.
- R4: Command 05h streams the status byte, repeated for as long as clocks continue. Its layout is bit0 = busy (WIP), bit1 = write-enable latch, bit2 = bpIn[0], bit3 = bpIn[1], bits 7..4 = 0. The status read is allowed while busy.
- R5: Command 06h sets the write-enable latch only if select rises with exactly eight bits clocked. If further bits are clocked before select rises, including a following 02h, the latch is left unchanged.
- R6: Command 04h clears the write-enable latch under the same exact-eight-bits rule. The latch also clears when `busyIn` falls.
- R7: Command 02h with the latch set and `busyIn` low, followed by an address byte, presents each complete data byte on `wrValid`/`wrAddr`/`wrData`. The address advances within its 16-byte page, so xFh is followed by x0h. With the latch clear, no byte is presented.
- R8: `wrCommit` pulses for one cycle, two core cycles after select is sampled high, only if the write received at least one byte and select rose on a byte boundary.
- R9: A read command issued while `busyIn` is high makes no array access and leaves SO disabled.
- R10: Any other command value is ignored until select rises: there is no array access and no SO drive.
- R11: While hold is low, SCK edges are ignored and SO is disabled. After hold is released, the transfer continues from the same bit.
- R12: SO is disabled whenever select is high. After reset, SO is disabled and no array or write strobes are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock that oversamples the serial pins |
| rstN | input | 1 | asynchronous active-low reset |
| sckIn | input | 1 | serial clock from the host |
| csN | input | 1 | active-low chip select |
| siIn | input | 1 | serial data from the host |
| holdN | input | 1 | active-low pause request |
| soOut | output | 1 | serial data bit toward the host |
| soOe | output | 1 | output enable for the SO pad |
| busyIn | input | 1 | write cycle in progress, from the write engine |
| bpIn | input | 2 | block-protect bits reported in status |
| memRdEn | output | 1 | array read request |
| memAddr | output | 7 | array read address |
| memRdData | input | 8 | array read data, valid one cycle after the request |
| wrValid | output | 1 | one received data byte for the write engine |
| wrAddr | output | 7 | page-wrapped address of that byte |
| wrData | output | 8 | the received byte |
| wrCommit | output | 1 | write sequence closed on a byte boundary |

## Verification
The bench attacks the write-enable latch timing: a latch that armed on the eighth bit, rather than on the select rise that follows it, would let a 06h-02h pair in one selection write the array. It drives a write into the last two bytes of a page to catch an address that spills into the next page. It also drives a read across 7Fh to catch a pointer that stops at the top or keeps bit 7, and it breaks a write off mid-byte to catch a commit issued on any select rise. Reads under busy, unknown commands and a hold placed in the middle of a byte with SCK toggling show whether the design leaks SO drive, makes stray array accesses or loses its bit position.

// File: rtl/spiee_pkg.sv
package spiee_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [2:0] {PH_OPC, PH_ADDR, PH_DATA, PH_POST, PH_SKIP} phase_e;
  typedef enum logic [1:0] {M_RD, M_WR, M_SR} mode_e;
  typedef enum logic [1:0] {PD_NONE, PD_SET, PD_CLR} pend_e;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic shiftIn;      // take one SI bit
    logic capAddr;      // load pointer from received byte
    logic memReq;       // read array at pointer, then step pointer
    logic wrByte;       // hand received byte to write engine, page-step pointer
    logic loadTx;       // start a new output byte
    logic txFromStatus; // output byte source is status instead of array
    logic shiftTx;      // next output bit
    logic commit;       // write sequence closed validly
  } dpStrobe_t;
endpackage

// File: rtl/spiee_ctrl.sv
module spiee_ctrl
  import spiee_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              csN,
  input  logic              holdN,
  input  logic              busyIn,
  input  logic [BYTE_W-1:0] rxNext,
  output dpStrobe_t         st,
  output logic              wel,
  output logic              soOe
);
  logic   sckQ, csQ, busyQ;
  phase_e phase;
  mode_e  mode;
  pend_e  pend;
  logic [2:0] bitCnt, txCnt;
  logic   byteSeen, txActive, reqNext;
  logic   rise, fall, csRise, lastBit;

  // edges only count while selected and not paused (R1, R11)
  assign rise    = ~csN & holdN & sckIn & ~sckQ;
  assign fall    = ~csN & holdN & ~sckIn & sckQ;
  assign csRise  = csN & ~csQ;
  assign lastBit = (bitCnt == 3'd7);
  assign soOe    = txActive & ~csN & holdN;

  always_comb begin
    st         = '0;
    st.shiftIn = rise;
    st.memReq  = reqNext & ~csN;
    st.capAddr = rise & lastBit & (phase == PH_ADDR);
    st.wrByte  = rise & lastBit & (phase == PH_DATA) & (mode == M_WR);
    if (fall && phase == PH_DATA && mode != M_WR) begin
      if (txCnt == 3'd0) begin
        st.loadTx       = 1'b1;
        st.txFromStatus = (mode == M_SR);
      end else begin
        st.shiftTx = 1'b1;
      end
    end
    st.commit = csRise & (phase == PH_DATA) & (mode == M_WR) & byteSeen & (bitCnt == 3'd0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ <= 1'b0; csQ <= 1'b1; busyQ <= 1'b0;
      phase <= PH_OPC; mode <= M_RD; pend <= PD_NONE;
      bitCnt <= '0; txCnt <= '0;
      byteSeen <= 1'b0; txActive <= 1'b0; reqNext <= 1'b0; wel <= 1'b0;
    end else begin
      sckQ    <= sckIn;
      csQ     <= csN;
      busyQ   <= busyIn;
      reqNext <= 1'b0;
      if (csN) begin
        if (csRise && phase == PH_POST) begin
          if (pend == PD_SET) wel <= 1'b1;
          else if (pend == PD_CLR) wel <= 1'b0;
        end
        phase <= PH_OPC; bitCnt <= '0; txCnt <= '0;
        txActive <= 1'b0; byteSeen <= 1'b0; pend <= PD_NONE;
      end else begin
        if (rise) begin
          bitCnt <= bitCnt + 3'd1;
          case (phase)
            PH_OPC: if (lastBit) begin
              case (rxNext)
                OP_READ:  begin phase <= PH_ADDR; mode <= M_RD; end
                OP_WRITE: begin
                  mode  <= M_WR;
                  phase <= (wel && !busyIn) ? PH_ADDR : PH_SKIP;
                end
                OP_RDSR:  begin phase <= PH_DATA; mode <= M_SR; end
                OP_WREN:  begin phase <= PH_POST; pend <= PD_SET; end
                OP_WRDI:  begin phase <= PH_POST; pend <= PD_CLR; end
                default:  phase <= PH_SKIP;
              endcase
            end
            PH_ADDR: if (lastBit) begin
              if (mode == M_RD && busyIn) phase <= PH_SKIP;
              else begin
                phase   <= PH_DATA;
                reqNext <= (mode == M_RD);
              end
            end
            PH_DATA: if (lastBit && mode == M_WR) byteSeen <= 1'b1;
            PH_POST: begin phase <= PH_SKIP; pend <= PD_NONE; end
            default: ;
          endcase
        end
        if (fall && phase == PH_DATA && mode != M_WR) begin
          txCnt    <= txCnt + 3'd1;
          txActive <= 1'b1;
          if (txCnt == 3'd0 && mode == M_RD) reqNext <= 1'b1; // prefetch next byte
        end
      end
      if (busyQ && !busyIn) wel <= 1'b0;
    end
  end
endmodule

// File: rtl/spiee_dp.sv
module spiee_dp
  import spiee_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              siIn,
  input  dpStrobe_t         st,
  input  logic [BYTE_W-1:0] status,
  input  logic [BYTE_W-1:0] memRdData,
  output logic [BYTE_W-1:0] rxNext,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [BYTE_W-1:0] wrData,
  output logic              wrCommit,
  output logic              soOut
);
  logic [BYTE_W-1:0] shiftReg, nextByte, txReg, txSrc;
  logic [ADDR_W-1:0] ptr, pageNext;
  logic              rdValidQ;

  assign rxNext   = {shiftReg[BYTE_W-2:0], siIn};
  assign memRdEn  = st.memReq;
  assign memAddr  = ptr;
  assign txSrc    = st.txFromStatus ? status : nextByte;
  assign pageNext = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0; nextByte <= '0; txReg <= '0; ptr <= '0;
      rdValidQ <= 1'b0; wrValid <= 1'b0; wrAddr <= '0; wrData <= '0;
      wrCommit <= 1'b0; soOut <= 1'b0;
    end else begin
      rdValidQ <= st.memReq;
      wrValid  <= st.wrByte;
      wrCommit <= st.commit;
      if (rdValidQ) nextByte <= memRdData;
      if (st.shiftIn) shiftReg <= rxNext;
      if (st.capAddr) ptr <= rxNext[ADDR_W-1:0];
      else if (st.memReq) ptr <= ptr + 1'b1;
      else if (st.wrByte) ptr <= pageNext;
      if (st.wrByte) begin
        wrAddr <= ptr;
        wrData <= rxNext;
      end
      if (st.loadTx) begin
        soOut <= txSrc[BYTE_W-1];
        txReg <= {txSrc[BYTE_W-2:0], 1'b0};
      end else if (st.shiftTx) begin
        soOut <= txReg[BYTE_W-1];
        txReg <= {txReg[BYTE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_eeprom_front.sv
module spi_eeprom_front
  import spiee_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              csN,
  input  logic              siIn,
  input  logic              holdN,
  output logic              soOut,
  output logic              soOe,
  input  logic              busyIn,
  input  logic [1:0]        bpIn,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [BYTE_W-1:0] memRdData,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [BYTE_W-1:0] wrData,
  output logic              wrCommit
);
  dpStrobe_t         st;
  logic              wel;
  logic [BYTE_W-1:0] rxNext, status;

  assign status = {4'b0000, bpIn[1], bpIn[0], wel, busyIn};

  spiee_ctrl ctrl_i (
    .clk, .rstN, .sckIn, .csN, .holdN, .busyIn,
    .rxNext, .st, .wel, .soOe
  );

  spiee_dp #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) dp_i (
    .clk, .rstN, .siIn, .st, .status, .memRdData, .rxNext,
    .memRdEn, .memAddr, .wrValid, .wrAddr, .wrData, .wrCommit, .soOut
  );
endmodule

// File: rtl/spiee_checker.sv
module spiee_checker (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic holdN,
  input logic soOe,
  input logic memRdEn,
  input logic wrValid,
  input logic wrCommit
);
  // SO is never driven while deselected or paused
  assert_so_hiz_R12: assert property (@(posedge clk) disable iff (!rstN)
    (csN || !holdN) |-> !soOe);
  // same rule under hold
  assert_hold_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !holdN |-> !soOe);
  // array read, write byte and commit never overlap
  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRdEn, wrValid, wrCommit}));
  // commit follows a select rise by two cycles
  assert_commit_on_cs_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |-> ($past(csN) && !$past(csN, 2)));
  // a write byte is only produced from a selected transfer
  assert_wr_selected_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> !$past(csN));
endmodule

bind spi_eeprom_front spiee_checker chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .holdN(holdN), .soOe(soOe),
  .memRdEn(memRdEn), .wrValid(wrValid), .wrCommit(wrCommit)
);

// File: tb/spi_eeprom_front_tb_top.sv
module spi_eeprom_front_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sck = 1'b0, csN = 1'b1, si = 1'b0, holdN = 1'b1, busy = 1'b0;
  logic [1:0] bp = 2'b00;
  logic       soOut, soOe, memRdEn, wrValid, wrCommit;
  logic [6:0] memAddr, wrAddr;
  logic [7:0] memRdData, wrData;

  logic [7:0] mem [128];
  logic [6:0] wrLogA [64];
  logic [7:0] wrLogD [64];
  int wrCnt = 0, commitCnt = 0, rdCnt = 0;
  int vecs = 0, miss = 0;
  bit oeSeen;

  always #10 clk = ~clk; // 50 MHz

  spi_eeprom_front dut_i (
    .clk, .rstN, .sckIn(sck), .csN, .siIn(si), .holdN, .soOut, .soOe,
    .busyIn(busy), .bpIn(bp), .memRdEn, .memAddr, .memRdData,
    .wrValid, .wrAddr, .wrData, .wrCommit
  );

  // storage array and write-engine model
  always @(posedge clk) begin
    if (memRdEn) begin memRdData <= mem[memAddr]; rdCnt++; end
    if (wrValid) begin
      mem[wrAddr] <= wrData;
      if (wrCnt < 64) begin wrLogA[wrCnt] = wrAddr; wrLogD[wrCnt] = wrData; end
      wrCnt++;
    end
    if (wrCommit) commitCnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expStat(input logic welE, input logic wipE);
    return {4'b0000, bp[1], bp[0], welE, wipE};
  endfunction

  task automatic selLow();
    @(negedge clk) csN = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic selHigh();
    @(negedge clk) csN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // one byte, MSB first; holdAt >= 0 pauses after that bit position
  task automatic xferH(input logic [7:0] tx, input int holdAt, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) si = tx[i];
      repeat (3) @(negedge clk);
      rx[i] = soOut;
      if (soOe) oeSeen = 1'b1;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
      if (i == holdAt) begin
        repeat (3) @(negedge clk);
        holdN = 1'b0;
        for (int k = 0; k < 2; k++) begin
          repeat (3) @(negedge clk); si = ~si; sck = 1'b1;
          repeat (4) @(negedge clk); sck = 1'b0;
        end
        repeat (2) @(negedge clk);
        chk("R11 SO disabled under hold", soOe, 0);
        holdN = 1'b1;
      end
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xferH(tx, -1, rx);
  endtask

  task automatic oneCmd(input logic [7:0] op);
    logic [7:0] r;
    selLow(); xfer(op, r); selHigh();
  endtask

  task automatic readStat(output logic [7:0] s);
    logic [7:0] r;
    selLow(); xfer(8'h05, r); xfer(8'h00, s); selHigh();
  endtask

  task automatic readSeq(input logic [7:0] a, input int n, input string tag);
    logic [7:0] r;
    selLow(); xfer(8'h03, r); xfer(a, r);
    for (int j = 0; j < n; j++) begin
      xfer(8'h00, r);
      chk(tag, r, mem[7'(a[6:0] + 7'(j))]);
    end
    selHigh();
  endtask

  initial begin
    logic [7:0] s, r;
    int w0, c0, d0;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    chk("R12 reset SO disabled", soOe, 0);
    chk("R12 reset no array read", memRdEn, 0);
    chk("R12 reset no write byte", wrValid, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R4 status layout with block-protect bits
    bp = 2'b10; readStat(s); chk("R4 status BP1 at bit3", s, 8'h08);
    bp = 2'b01; readStat(s); chk("R4 status BP0 at bit2", s, 8'h04);
    bp = 2'b00;
    // R4 repeated status bytes
    selLow(); xfer(8'h05, r); xfer(8'h00, s); xfer(8'h00, r); selHigh();
    chk("R4 status repeats", r, s);

    // R5 latch set by exact eight bits
    oneCmd(8'h06); readStat(s); chk("R5 WREN sets latch", s, expStat(1, 0));
    // R6 clear
    oneCmd(8'h04); readStat(s); chk("R6 WRDI clears latch", s, expStat(0, 0));

    // R5 WREN then WRITE in one selection: no latch, no bytes
    w0 = wrCnt;
    selLow(); xfer(8'h06, r); xfer(8'h02, r); xfer(8'h10, r); xfer(8'h55, r); selHigh();
    readStat(s); chk("R5 WREN without select rise", s, expStat(0, 0));
    chk("R7 no byte without latch", wrCnt - w0, 0);

    // R7/R8 page-wrapping write with commit
    oneCmd(8'h06);
    w0 = wrCnt; c0 = commitCnt;
    selLow(); xfer(8'h02, r); xfer(8'h8E, r);
    xfer(8'hA1, r); xfer(8'hB2, r); xfer(8'hC3, r); selHigh();
    chk("R7 byte count", wrCnt - w0, 3);
    chk("R7 first address", wrLogA[w0], 7'h0E);
    chk("R7 page end address", wrLogA[w0 + 1], 7'h0F);
    chk("R7 page wrap address", wrLogA[w0 + 2], 7'h00);
    chk("R7 data byte", wrLogD[w0 + 2], 8'hC3);
    chk("R8 commit on byte boundary", commitCnt - c0, 1);
    busy = 1'b1;

    // R4 status allowed while busy
    readStat(s); chk("R4 status during busy", s, expStat(1, 1));
    // R9 read refused while busy
    d0 = rdCnt; oeSeen = 1'b0;
    selLow(); xfer(8'h03, r); xfer(8'h20, r); xfer(8'h00, r); xfer(8'h00, r); selHigh();
    chk("R9 no array access when busy", rdCnt - d0, 0);
    chk("R9 SO disabled when busy", oeSeen, 0);
    @(negedge clk) busy = 1'b0;
    repeat (3) @(negedge clk);
    readStat(s); chk("R6 latch cleared at end of busy", s, expStat(0, 0));

    // R7 write with latch clear presents nothing
    w0 = wrCnt;
    selLow(); xfer(8'h02, r); xfer(8'h30, r); xfer(8'h77, r); selHigh();
    chk("R7 write ignored with latch clear", wrCnt - w0, 0);

    // R8 select rise mid-byte: no commit
    oneCmd(8'h06);
    w0 = wrCnt; c0 = commitCnt;
    selLow(); xfer(8'h02, r); xfer(8'h20, r); xfer(8'h5A, r);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) si = 1'b1; repeat (3) @(negedge clk); sck = 1'b1;
      repeat (4) @(negedge clk); sck = 1'b0;
    end
    selHigh();
    chk("R8 no commit mid-byte", commitCnt - c0, 0);
    chk("R7 complete byte still presented", wrCnt - w0, 1);
    oneCmd(8'h04);

    // R2/R3 wrap across 7Fh, address bit 7 ignored
    readSeq(8'hFE, 4, "R3 read wraps 7Fh to 00h");
    chk("R12 SO disabled after deselect", soOe, 0);

    // R1/R2/R3 random reads
    for (int t = 0; t < 20; t++) begin
      readSeq(8'($urandom), 1 + int'($urandom % 4), "R2 random sequential read");
    end

    // R10 unknown command ignored
    d0 = rdCnt; oeSeen = 1'b0;
    selLow(); xfer(8'hAB, r); xfer(8'h03, r); xfer(8'h10, r); xfer(8'h00, r); selHigh();
    chk("R10 unknown command no access", rdCnt - d0, 0);
    chk("R10 unknown command no SO", oeSeen, 0);

    // R11 hold in the middle of a data byte
    selLow(); xfer(8'h03, r); xfer(8'h41, r);
    xferH(8'h00, 4, r); chk("R11 byte across hold", r, mem[7'h41]);
    xfer(8'h00, r); chk("R11 next byte after hold", r, mem[7'h42]);
    selHigh();

    // R1 first sample after select falls
    selLow(); xfer(8'h03, r); xfer(8'h05, r); xfer(8'h00, r); selHigh();
    chk("R1 first bit after select", r, mem[7'h05]);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule